// File: doc/BRIEF.md
# Idle State Save-Restore Power Controller

This block sequences one core into and out of its deepest idle state. When the core asks to go idle, the controller reads each architectural state word out of the core and writes it, protected by a single-error-correcting, double-error-detecting code, into a retention SRAM. That SRAM sits on a rail that stays powered while the core rail is off. Once the last word is stored, the controller stops the core clock, then the PLL, then the core supply.

A wake (break) event brings the rails back in the opposite order. The core supply comes up first and is given a fixed settle time. The PLL is then enabled, and the core clock is released once the PLL reports lock. The controller then reads every word back, corrects any single-bit error, writes the word into the core and pulses a one-cycle resume indication. A double-bit error stops the restore and raises a sticky fatal flag. A wake that arrives while the state is still being saved, or while the rails are being turned off, is remembered. A wake seen before the save finishes sends the controller straight to restore without dropping any rail. The whole sequence can be repeated indefinitely.

The SRAM has a one-cycle read latency. The core state port is combinational on reads and takes writes on the clock edge. By default the controller handles 1024 words of 64 bits (8 KB), each stored as a 72-bit codeword.

Top module: `idle_retention_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, vcore_en, pll_en and clk_en are 1, st_rd, st_wr, sram_en and resume_done are 0, ecc_fatal is 0 and corr_cnt is 0.
- R2: An idle_req sampled high while running starts a save of NWORDS cycles, beginning on the next cycle. In save cycle i, st_rd=1 and st_addr=i, and the SRAM sees sram_en=1, sram_we=1, sram_addr=i and the codeword of st_rdata.
- R3: After the last save cycle (with no pending wake), clk_en drops first, pll_en drops one cycle later and vcore_en one cycle after that. All three then stay low until a wake.
- R4: A wake in the sleep state raises vcore_en on the next cycle. pll_en rises SETTLE_CYC cycles later. clk_en rises on the cycle after pll_lock is sampled high with pll_en set.
- R5: During restore, word k is read from SRAM address k in restore cycle k. It is written back to core address k, corrected, in restore cycle k+1 with st_wr=1.
- R6: resume_done is high for exactly one cycle, on the cycle after the final word's write-back. The controller is then running again and accepts a new idle_req.
- R7: A word with one flipped bit, in any of the 72 codeword positions, is restored with its original value, and corr_cnt increases by one for it. corr_cnt saturates at its all-ones value.
- R8: A word with two flipped bits sets ecc_fatal on the next cycle, and ecc_fatal stays set until reset. That word and all later words are not written. resume_done is never asserted for that restore, and clk_en stays low.
- R9: A wake seen during the save (including its last cycle) skips the power-down entirely: restore starts on the cycle after the last save cycle, and vcore_en never drops. A wake seen while clk_en or pll_en is being turned off lets power-down finish, then starts power-up after one cycle in sleep.
- R10: idle_req outside the running state and wake while running have no effect on rails, SRAM or core port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Request to enter the deep idle state |
| wake | input | 1 | Break event requesting exit |
| st_rd | output | 1 | Core state read strobe |
| st_wr | output | 1 | Core state write strobe |
| st_addr | output | log2(NWORDS) | Core state word index |
| st_rdata | input | DATA_W | Core state read data, valid in the same cycle |
| st_wdata | output | DATA_W | Restored, corrected state word |
| sram_en | output | 1 | Retention SRAM access enable |
| sram_we | output | 1 | Retention SRAM write (1) or read (0) |
| sram_addr | output | log2(NWORDS) | Retention SRAM word address |
| sram_wdata | output | DATA_W+8 | Encoded codeword to store |
| sram_rdata | input | DATA_W+8 | Codeword read, one cycle after the read |
| vcore_en | output | 1 | Core supply enable |
| pll_en | output | 1 | PLL enable |
| pll_lock | input | 1 | PLL lock indication |
| clk_en | output | 1 | Core clock enable |
| resume_done | output | 1 | One-cycle pulse: state restored |
| ecc_fatal | output | 1 | Sticky uncorrectable-error flag |
| corr_cnt | output | CNT_W | Saturating count of corrected words |

## Verification
Save writes appear one cycle after idle_req, rail changes one cycle after the state that causes them, restore write-backs one cycle after each SRAM read, and ecc_fatal, corr_cnt and resume_done one cycle after the write-back cycle that produces them. The bench runs a behavioural model that advances on the same clock edge from the same inputs. It compares every output on the opposite edge, so each result is checked in exactly the cycle it is due. Scenario checks after each resume or fault then compare the core's state words against the values captured when the save began.

// File: rtl/idle_retention_pkg.sv
package idle_retention_pkg;

    typedef enum logic [3:0] {
        PH_RUN,
        PH_SAVE,
        PH_CLK_OFF,
        PH_PLL_OFF,
        PH_SLEEP,
        PH_VDD_UP,
        PH_PLL_UP,
        PH_RESTORE,
        PH_FAULT
    } phase_e;

    // Number of Hamming check bits needed to cover dw data bits.
    function automatic int ecc_hbits(input int dw);
        int res;
        res = 0;
        for (int r = 30; r >= 1; r--) begin
            if ((1 << r) >= dw + r + 1) res = r;
        end
        return res;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]                                         data,
    output logic [DATA_W+idle_retention_pkg::ecc_hbits(DATA_W):0]     cw
);
    import idle_retention_pkg::*;

    localparam int HB   = ecc_hbits(DATA_W);
    localparam int CW_W = DATA_W + HB + 1;

    logic [CW_W-1:0] c;
    logic [HB-1:0]   syn;

    always_comb begin
        int k;
        c   = '0;
        syn = '0;
        k   = 0;
        // scatter data over non power-of-two positions
        for (int pos = 1; pos < CW_W; pos++) begin
            if (!is_pow2(pos)) begin
                c[pos] = data[k];
                k++;
            end
        end
        for (int pos = 1; pos < CW_W; pos++) begin
            if (c[pos]) syn = syn ^ HB'(pos);
        end
        for (int j = 0; j < HB; j++) begin
            c[1 << j] = syn[j];
        end
        c[0] = ^c[CW_W-1:1];
    end

    assign cw = c;

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W+idle_retention_pkg::ecc_hbits(DATA_W):0] cw,
    output logic [DATA_W-1:0]                                     data,
    output logic                                                  sec,
    output logic                                                  ded
);
    import idle_retention_pkg::*;

    localparam int HB   = ecc_hbits(DATA_W);
    localparam int CW_W = DATA_W + HB + 1;

    logic [HB-1:0]   syn;
    logic            ovp;
    logic [CW_W-1:0] fixed;

    always_comb begin
        int k;
        syn = '0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if (cw[pos]) syn = syn ^ HB'(pos);
        end
        ovp   = ^cw;
        sec   = ovp && (int'(syn) < CW_W);
        ded   = (!ovp && (syn != '0)) || (ovp && (int'(syn) >= CW_W));
        fixed = cw;
        for (int pos = 0; pos < CW_W; pos++) begin
            if (sec && (HB'(pos) == syn)) fixed[pos] = ~cw[pos];
        end
        data = '0;
        k    = 0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if (!is_pow2(pos)) begin
                data[k] = fixed[pos];
                k++;
            end
        end
    end

endmodule

// File: rtl/idle_retention_ctrl.sv
module idle_retention_ctrl #(
    parameter int NWORDS     = 1024,
    parameter int DATA_W     = 64,
    parameter int SETTLE_CYC = 8,
    parameter int CNT_W      = 8
) (
    input  logic                                                      clk,
    input  logic                                                      rst_n,
    input  logic                                                      idle_req,
    input  logic                                                      wake,
    output logic                                                      st_rd,
    output logic                                                      st_wr,
    output logic [$clog2(NWORDS)-1:0]                                 st_addr,
    input  logic [DATA_W-1:0]                                         st_rdata,
    output logic [DATA_W-1:0]                                         st_wdata,
    output logic                                                      sram_en,
    output logic                                                      sram_we,
    output logic [$clog2(NWORDS)-1:0]                                 sram_addr,
    output logic [DATA_W+idle_retention_pkg::ecc_hbits(DATA_W):0]     sram_wdata,
    input  logic [DATA_W+idle_retention_pkg::ecc_hbits(DATA_W):0]     sram_rdata,
    output logic                                                      vcore_en,
    output logic                                                      pll_en,
    input  logic                                                      pll_lock,
    output logic                                                      clk_en,
    output logic                                                      resume_done,
    output logic                                                      ecc_fatal,
    output logic [CNT_W-1:0]                                          corr_cnt
);
    import idle_retention_pkg::*;

    localparam int AW   = $clog2(NWORDS);
    localparam int SW   = $clog2(SETTLE_CYC + 1);
    localparam logic [AW-1:0]    LAST_IDX   = AW'(NWORDS - 1);
    localparam logic [SW-1:0]    SETTLE_END = SW'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};

    typedef struct packed {
        phase_e            ph;
        logic [AW-1:0]     idx;
        logic              issued;
        logic              rd_pend;
        logic [AW-1:0]     wb_addr;
        logic              wk;
        logic [SW-1:0]     settle;
        logic              resume;
        logic              fatal;
        logic [CNT_W-1:0]  corr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DATA_W-1:0] dec_data;
    logic              dec_sec;
    logic              dec_ded;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data (st_rdata),
        .cw   (sram_wdata)
    );

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .cw   (sram_rdata),
        .data (dec_data),
        .sec  (dec_sec),
        .ded  (dec_ded)
    );

    // rail enables follow the phase
    always_comb begin
        vcore_en = 1'b1;
        pll_en   = 1'b1;
        clk_en   = 1'b1;
        unique case (ctl_q.ph)
            PH_CLK_OFF, PH_PLL_UP, PH_FAULT: clk_en = 1'b0;
            PH_PLL_OFF, PH_VDD_UP: begin
                clk_en = 1'b0;
                pll_en = 1'b0;
            end
            PH_SLEEP: begin
                clk_en   = 1'b0;
                pll_en   = 1'b0;
                vcore_en = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.resume = 1'b0;
        st_rd        = 1'b0;
        st_wr        = 1'b0;
        st_addr      = '0;
        st_wdata     = '0;
        sram_en      = 1'b0;
        sram_we      = 1'b0;
        sram_addr    = '0;

        if (wake && (ctl_q.ph inside {PH_SAVE, PH_CLK_OFF, PH_PLL_OFF}))
            ctl_d.wk = 1'b1;

        unique case (ctl_q.ph)
            PH_RUN: begin
                if (idle_req) begin
                    ctl_d.ph  = PH_SAVE;
                    ctl_d.idx = '0;
                    ctl_d.wk  = 1'b0;
                end
            end
            PH_SAVE: begin
                st_rd     = 1'b1;
                st_addr   = ctl_q.idx;
                sram_en   = 1'b1;
                sram_we   = 1'b1;
                sram_addr = ctl_q.idx;
                ctl_d.idx = ctl_q.idx + AW'(1);
                if (ctl_q.idx == LAST_IDX) begin
                    if (ctl_d.wk) begin
                        ctl_d.ph      = PH_RESTORE;
                        ctl_d.idx     = '0;
                        ctl_d.issued  = 1'b0;
                        ctl_d.rd_pend = 1'b0;
                        ctl_d.wk      = 1'b0;
                    end else begin
                        ctl_d.ph = PH_CLK_OFF;
                    end
                end
            end
            PH_CLK_OFF: ctl_d.ph = PH_PLL_OFF;
            PH_PLL_OFF: ctl_d.ph = PH_SLEEP;
            PH_SLEEP: begin
                if (ctl_q.wk || wake) begin
                    ctl_d.ph     = PH_VDD_UP;
                    ctl_d.settle = '0;
                    ctl_d.wk     = 1'b0;
                end
            end
            PH_VDD_UP: begin
                if (ctl_q.settle == SETTLE_END) ctl_d.ph = PH_PLL_UP;
                else ctl_d.settle = ctl_q.settle + SW'(1);
            end
            PH_PLL_UP: begin
                if (pll_lock) begin
                    ctl_d.ph      = PH_RESTORE;
                    ctl_d.idx     = '0;
                    ctl_d.issued  = 1'b0;
                    ctl_d.rd_pend = 1'b0;
                end
            end
            PH_RESTORE: begin
                if (!ctl_q.issued) begin
                    sram_en   = 1'b1;
                    sram_addr = ctl_q.idx;
                    ctl_d.idx = ctl_q.idx + AW'(1);
                    if (ctl_q.idx == LAST_IDX) ctl_d.issued = 1'b1;
                end
                ctl_d.rd_pend = !ctl_q.issued;
                ctl_d.wb_addr = ctl_q.idx;
                if (ctl_q.rd_pend) begin
                    if (dec_ded) begin
                        ctl_d.fatal   = 1'b1;
                        ctl_d.ph      = PH_FAULT;
                        ctl_d.rd_pend = 1'b0;
                    end else begin
                        st_wr    = 1'b1;
                        st_addr  = ctl_q.wb_addr;
                        st_wdata = dec_data;
                        if (dec_sec && (ctl_q.corr != CNT_MAX))
                            ctl_d.corr = ctl_q.corr + CNT_W'(1);
                        if (ctl_q.wb_addr == LAST_IDX) begin
                            ctl_d.ph     = PH_RUN;
                            ctl_d.resume = 1'b1;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_RUN, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign resume_done = ctl_q.resume;
    assign ecc_fatal   = ctl_q.fatal;
    assign corr_cnt    = ctl_q.corr;

endmodule

// File: rtl/idle_retention_chk.sv
module idle_retention_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vcore_en,
    input logic             pll_en,
    input logic             clk_en,
    input logic             pll_lock,
    input logic             st_wr,
    input logic             sram_en,
    input logic             sram_we,
    input logic             resume_done,
    input logic             ecc_fatal,
    input logic [CNT_W-1:0] corr_cnt
);

    // R3
    pll_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> $past(!clk_en));

    // R3
    vdd_after_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcore_en) |-> $past(!pll_en));

    // R4
    pll_needs_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(vcore_en));

    // R4
    clk_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> $past(pll_lock && pll_en));

    // R5
    wb_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> $past(sram_en && !sram_we));

    // R6
    resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_done |=> !resume_done);

    // R6
    resume_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_done |-> $past(st_wr));

    // R7
    corr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(corr_cnt) |-> (corr_cnt == $past(corr_cnt) + CNT_W'(1)));

    // R8
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_fatal |=> ecc_fatal);

    // R8
    fatal_no_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_fatal |-> !resume_done);

endmodule

bind idle_retention_ctrl idle_retention_chk #(.CNT_W(CNT_W)) u_idle_retention_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vcore_en    (vcore_en),
    .pll_en      (pll_en),
    .clk_en      (clk_en),
    .pll_lock    (pll_lock),
    .st_wr       (st_wr),
    .sram_en     (sram_en),
    .sram_we     (sram_we),
    .resume_done (resume_done),
    .ecc_fatal   (ecc_fatal),
    .corr_cnt    (corr_cnt)
);

// File: tb/test_idle_retention_ctrl.sv
`timescale 1ns/1ps
module test_idle_retention_ctrl;

    localparam int N   = 16;
    localparam int DW  = 64;
    localparam int CWW = 72;
    localparam int ST  = 5;
    localparam int CN  = 3;
    localparam int AW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 1'b0, wake = 1'b0, pll_lock = 1'b0;
    logic st_rd, st_wr, sram_en, sram_we, vcore_en, pll_en, clk_en;
    logic resume_done, ecc_fatal;
    logic [AW-1:0]  st_addr, sram_addr;
    logic [DW-1:0]  st_rdata, st_wdata;
    logic [CWW-1:0] sram_wdata;
    logic [CWW-1:0] sram_rdata = '0;
    logic [CN-1:0]  corr_cnt;

    always #5 clk = ~clk;

    idle_retention_ctrl #(.NWORDS(N), .DATA_W(DW), .SETTLE_CYC(ST), .CNT_W(CN)) i_idle_retention_ctrl (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .wake(wake),
        .st_rd(st_rd), .st_wr(st_wr), .st_addr(st_addr), .st_rdata(st_rdata), .st_wdata(st_wdata),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .vcore_en(vcore_en), .pll_en(pll_en), .pll_lock(pll_lock), .clk_en(clk_en),
        .resume_done(resume_done), .ecc_fatal(ecc_fatal), .corr_cnt(corr_cnt)
    );

    // core state and retention memory models
    logic [DW-1:0]  core_regs [N];
    logic [CWW-1:0] mem [N];
    int             flips [N];
    logic [DW-1:0]  golden [N];

    assign st_rdata = core_regs[st_addr];

    always @(posedge clk) begin
        if (st_wr) core_regs[st_addr] <= st_wdata;
        if (sram_en && sram_we) mem[sram_addr] <= sram_wdata;
        if (sram_en && !sram_we) sram_rdata <= mem[sram_addr];
    end

    int checks = 0;
    int failures = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phase names as plain integers
    // 0 run,1 save,2 clock stop,3 pll stop,4 sleep,5 supply up,6 pll up,7 restore,8 fault
    int m_ph = 0, m_sc = 0, m_rc = 0, m_vc = 0, m_cnt = 0;
    bit m_wk = 0, m_res = 0, m_fat = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_sc = 0; m_rc = 0; m_vc = 0; m_cnt = 0;
            m_wk = 0; m_res = 0; m_fat = 0;
        end else begin
            bit r;
            r = 0;
            if (wake && (m_ph == 1 || m_ph == 2 || m_ph == 3)) m_wk = 1;
            case (m_ph)
                0: if (idle_req) begin
                       m_ph = 1; m_sc = 0; m_wk = 0;
                       for (int i = 0; i < N; i++) golden[i] = core_regs[i];
                   end
                1: if (m_sc == N - 1) begin
                       if (m_wk) begin m_ph = 7; m_rc = 0; m_wk = 0; end
                       else m_ph = 2;
                   end else m_sc++;
                2: m_ph = 3;
                3: m_ph = 4;
                4: if (m_wk || wake) begin m_ph = 5; m_vc = 0; m_wk = 0; end
                5: if (m_vc == ST - 1) m_ph = 6; else m_vc++;
                6: if (pll_lock) begin m_ph = 7; m_rc = 0; end
                7: begin
                       if (m_rc >= 1) begin
                           if (flips[m_rc-1] >= 2) begin
                               m_fat = 1; m_ph = 8;
                           end else begin
                               if (flips[m_rc-1] == 1 && m_cnt < (1 << CN) - 1) m_cnt++;
                               if (m_rc - 1 == N - 1) begin m_ph = 0; r = 1; end
                           end
                       end
                       m_rc++;
                   end
                default: ;
            endcase
            m_res = r;
        end
    end

    bit saw_drop = 0;
    bit saw_sram = 0;

    always @(negedge clk) begin
        logic [2:0] er;
        bit ewr, een, ewe;
        int ea;
        case (m_ph)
            2, 6, 8: er = 3'b110;
            3, 5:    er = 3'b100;
            4:       er = 3'b000;
            default: er = 3'b111;
        endcase
        chk("R3,R4 rails {vcore,pll,clk}", {61'd0, vcore_en, pll_en, clk_en}, {61'd0, er});
        ewr = (m_ph == 7) && (m_rc >= 1) && (flips[(m_rc >= 1) ? m_rc - 1 : 0] < 2);
        chk("R5 st_wr", {63'd0, st_wr}, {63'd0, ewr});
        if (ewr && st_wr) begin
            chk("R5 st_addr", {60'd0, st_addr}, 64'(m_rc - 1));
            chk("R5 R7 st_wdata", st_wdata, golden[m_rc-1]);
        end
        een = (m_ph == 1) || (m_ph == 7 && m_rc < N);
        ewe = (m_ph == 1);
        ea  = (m_ph == 1) ? m_sc : m_rc;
        chk("R2 sram_en", {63'd0, sram_en}, {63'd0, een});
        chk("R2 sram_we", {63'd0, sram_we}, {63'd0, ewe});
        chk("R2 st_rd", {63'd0, st_rd}, {63'd0, ewe});
        if (een && sram_en) chk("R2 sram_addr", {60'd0, sram_addr}, 64'(ea));
        chk("R6 resume_done", {63'd0, resume_done}, {63'd0, m_res});
        chk("R8 ecc_fatal", {63'd0, ecc_fatal}, {63'd0, m_fat});
        chk("R7 corr_cnt", {61'd0, corr_cnt}, 64'(m_cnt));
        if (!vcore_en) saw_drop = 1;
        if (sram_en) saw_sram = 1;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [DW-1:0] pattern(input int i, input int seed);
        return {32'(seed * 32'h9E37_79B9 + i), 32'(i * 32'h0101_0101) ^ 32'(seed)};
    endfunction

    function automatic logic [DW-1:0] scramble(input int i);
        return 64'hDEAD_BEEF_0000_0000 | 64'(i);
    endfunction

    task automatic load_core(input int seed);
        for (int i = 0; i < N; i++) core_regs[i] = pattern(i, seed);
        for (int i = 0; i < N; i++) flips[i] = 0;
    endtask

    task automatic pulse_idle();
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
    endtask

    task automatic wait_sleep();
        for (int t = 0; t < 100 && vcore_en; t++) @(negedge clk);
        chk("R3 reached sleep", {63'd0, vcore_en}, 64'd0);
    endtask

    task automatic wake_and_wait(input int lock_delay);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        for (int t = 0; t < 100 && !pll_en; t++) @(negedge clk);
        repeat (lock_delay) @(negedge clk);
        pll_lock = 1'b1;
        for (int t = 0; t < 200 && !resume_done && !ecc_fatal; t++) @(negedge clk);
        pll_lock = 1'b0;
    endtask

    task automatic wait_resume();
        for (int t = 0; t < 200 && !resume_done; t++) @(negedge clk);
        chk("R6 resume seen", {63'd0, resume_done}, 64'd1);
    endtask

    task automatic check_restored(input string tag);
        for (int i = 0; i < N; i++) chk(tag, core_regs[i], golden[i]);
    endtask

    initial begin
        load_core(1);
        repeat (3) @(negedge clk);
        // R1 reset values while held
        chk("R1 rails in reset", {61'd0, vcore_en, pll_en, clk_en}, 64'd7);
        chk("R1 no access in reset", {60'd0, st_rd, st_wr, sram_en, resume_done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fatal and count", {60'd0, ecc_fatal, corr_cnt}, 64'd0);

        // R10: wake while running does nothing
        saw_sram = 0;
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 wake while running", {62'd0, saw_sram, vcore_en}, 64'd1);

        // plain cycle with supply loss (R2 R3 R4 R5 R6)
        pulse_idle();
        wait_sleep();
        for (int i = 0; i < N; i++) core_regs[i] = scramble(i);
        repeat (3) @(negedge clk);
        // R10: idle request during sleep ignored
        pulse_idle();
        repeat (2) @(negedge clk);
        chk("R10 idle_req in sleep", {61'd0, vcore_en, pll_en, clk_en}, 64'd0);
        wake_and_wait(4);
        chk("R6 first resume", {63'd0, resume_done}, 64'd1);
        @(negedge clk);
        check_restored("R5 plain restore");

        // repeat immediately with new contents (R6)
        load_core(2);
        pulse_idle();
        wait_sleep();
        for (int i = 0; i < N; i++) core_regs[i] = scramble(i);
        wake_and_wait(0);
        @(negedge clk);
        check_restored("R6 repeated restore");

        // R7: one flipped bit per word, includes overall parity position 0
        load_core(3);
        pulse_idle();
        wait_sleep();
        for (int i = 0; i < N; i++) begin
            mem[i][(i * 5) % CWW] = ~mem[i][(i * 5) % CWW];
            flips[i] = 1;
            core_regs[i] = scramble(i);
        end
        wake_and_wait(2);
        @(negedge clk);
        check_restored("R7 corrected restore");
        chk("R7 corr_cnt saturated", {61'd0, corr_cnt}, 64'd7);

        // R9: wake during save, no rail drops
        load_core(4);
        saw_drop = 0;
        pulse_idle();
        repeat (3) @(negedge clk);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        wait_resume();
        @(negedge clk);
        chk("R9 supply never dropped", {63'd0, saw_drop}, 64'd0);
        check_restored("R9 skip restore");

        // R9: wake on the last save cycle
        load_core(5);
        saw_drop = 0;
        pulse_idle();
        repeat (N - 2) @(negedge clk);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        wait_resume();
        chk("R9 last-cycle wake no drop", {63'd0, saw_drop}, 64'd0);

        // R9: wake during pll stop, power-down completes then powers up
        load_core(6);
        saw_drop = 0;
        pulse_idle();
        repeat (N + 1) @(negedge clk);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        for (int t = 0; t < 100 && !pll_en; t++) @(negedge clk);
        chk("R9 late wake still slept", {63'd0, saw_drop}, 64'd1);
        pll_lock = 1'b1;
        wait_resume();
        pll_lock = 1'b0;
        @(negedge clk);
        check_restored("R9 late wake restore");

        // R8: double error in word 5
        load_core(7);
        pulse_idle();
        wait_sleep();
        for (int i = 0; i < N; i++) core_regs[i] = scramble(i);
        mem[5][10] = ~mem[5][10];
        mem[5][40] = ~mem[5][40];
        flips[5] = 2;
        wake_and_wait(1);
        repeat (4) @(negedge clk);
        chk("R8 fatal raised", {63'd0, ecc_fatal}, 64'd1);
        chk("R8 clock held", {63'd0, clk_en}, 64'd0);
        chk("R8 earlier word restored", core_regs[4], golden[4]);
        chk("R8 bad word untouched", core_regs[5], scramble(5));
        chk("R8 later word untouched", core_regs[N-1], scramble(N - 1));

        // R1: reset clears fault
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fault cleared", {60'd0, ecc_fatal, corr_cnt}, 64'd0);
        chk("R1 rails after reset", {61'd0, vcore_en, pll_en, clk_en}, 64'd7);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule